// File: doc/BRIEF.md
# I2C Master Bus Timing Generator

This block gives an I2C master's bit-level engine its bus timing. A configuration port loads five values: a 4-bit prescaler, 8-bit counts for the SCL low and SCL high phases, and 4-bit counts for the data-hold and data-setup delays. The block divides the input clock by (prescaler+1) to make a single time base. The SCL phases and both data delays are all counted in units of that time base.

The engine asks for one operation at a time with a 2-bit code.

- **Bit operation.** The block pulses a strobe when SCL must be pulled low. It pulses a second strobe when SDA may change, once the hold delay has passed. It pulses a third strobe when SCL may be released, once both the low phase and the hold-plus-setup time have passed. It then waits until the sampled SCL input reads high, so a slave can stretch the clock. Only then does it time the high phase and pulse a completion strobe.
- **Interval operations.** These time the START hold and STOP setup intervals, which reuse the high count. They also time the bus-free and repeated-START setup intervals, which reuse the low count.

Configuration can be changed only while the block is disabled. An operation that is running therefore always uses one consistent set of values.

Top module: `i2c_bus_timer`

## Requirements
- R1: While reset is held, and after reset, all four strobes are low and `cmd_ready` is low while `enable` is low.
- R2: A configuration write (`cfg_we` high at a rising edge) is stored only if `enable` is low at that edge. A write while `enable` is high has no effect, and later operations keep the previously stored timing.
- R3: The time base period P is (prescaler+1) clocks. When a bit operation (code 0) is accepted at a rising edge, `scl_fall_stb` is high for exactly the following cycle.
- R4: `sda_chg_stb` pulses hold×P clocks after `scl_fall_stb`. A hold count of zero makes it pulse in the same cycle as `scl_fall_stb`.
- R5: `scl_rise_stb` pulses max(low+1, hold+setup+1)×P clocks after `scl_fall_stb`.
- R6: After `scl_rise_stb`, the block waits for the first rising edge at which `scl_in` is sampled high. `done_stb` pulses (high+1)×P clocks after that edge.
- R7: Code 1 makes `done_stb` pulse (high+1)×P clocks after the accepting edge. Code 2 does the same with (low+1)×P. Neither code produces a fall, SDA or rise strobe.
- R8: Code 3 is reserved and has no effect. No strobe follows and `cmd_ready` stays high.
- R9: `cmd_ready` is high exactly when `enable` is high and no operation is running. A command is taken only at an edge where `cmd_valid` and `cmd_ready` are both high.
- R10: If `enable` is low at a rising edge, any running operation is abandoned. From the next cycle no strobe pulses and the block is idle.
- R11: `scl_fall_stb`, `scl_rise_stb` and `done_stb` are never high in the same cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low blocks operations and opens configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_presc | input | 4 | Prescaler value (period = value+1 clocks) |
| cfg_low | input | 8 | SCL low count |
| cfg_high | input | 8 | SCL high count |
| cfg_hold | input | 4 | Data hold count (no +1) |
| cfg_setup | input | 4 | Data setup count |
| scl_in | input | 1 | Sampled SCL line level, synchronous to clk |
| cmd_valid | input | 1 | Operation request |
| cmd_op | input | 2 | 0 bit, 1 high-count interval, 2 low-count interval, 3 reserved |
| cmd_ready | output | 1 | Block idle and able to take a request |
| scl_fall_stb | output | 1 | Pull SCL low now |
| sda_chg_stb | output | 1 | SDA may change now |
| scl_rise_stb | output | 1 | Release SCL now |
| done_stb | output | 1 | Operation finished |

## Verification
The assertions assume that `scl_in` is already synchronous to `clk` and that `cmd_op` never carries unknown bits. They also assume that `scl_in` may stay low for any length of time after a release, since clock stretching has no bound. The stimulus drives every input on the falling clock edge. It holds `scl_in` low from each fall strobe until a chosen number of cycles after the rise strobe, and that number includes zero. Configuration writes are issued both with the block disabled and, on purpose, with it enabled.

// File: rtl/i2c_bus_timer_pkg.sv
package i2c_bus_timer_pkg;

    typedef enum logic [1:0] {
        OP_BIT       = 2'd0,
        OP_HIGH_IVAL = 2'd1,
        OP_LOW_IVAL  = 2'd2,
        OP_RSVD      = 2'd3
    } tmg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOW     = 3'd1,
        ST_WAIT_HI = 3'd2,
        ST_HIGH    = 3'd3,
        ST_IVAL    = 3'd4
    } tmg_state_e;

endpackage

// File: rtl/i2c_tmg_cfg.sv
module i2c_tmg_cfg #(
    parameter int PRESC_W = 4,
    parameter int PHASE_W = 8,
    parameter int DLY_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               wr,
    input  logic [PRESC_W-1:0] wr_presc,
    input  logic [PHASE_W-1:0] wr_low,
    input  logic [PHASE_W-1:0] wr_high,
    input  logic [DLY_W-1:0]   wr_hold,
    input  logic [DLY_W-1:0]   wr_setup,
    output logic [PRESC_W-1:0] presc,
    output logic [PHASE_W-1:0] low,
    output logic [PHASE_W-1:0] high,
    output logic [DLY_W-1:0]   hold,
    output logic [DLY_W-1:0]   setup
);
    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [PHASE_W-1:0] low;
        logic [PHASE_W-1:0] high;
        logic [DLY_W-1:0]   hold;
        logic [DLY_W-1:0]   setup;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr && !enable) begin
            cfg_d.presc = wr_presc;
            cfg_d.low   = wr_low;
            cfg_d.high  = wr_high;
            cfg_d.hold  = wr_hold;
            cfg_d.setup = wr_setup;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign presc = cfg_q.presc;
    assign low   = cfg_q.low;
    assign high  = cfg_q.high;
    assign hold  = cfg_q.hold;
    assign setup = cfg_q.setup;

    // R2: stored timing is frozen across any edge where the block is enabled
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cfg_q));

endmodule

// File: rtl/i2c_tmg_presc.sv
module i2c_tmg_presc #(
    parameter int PRESC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!run || p_q.cnt == presc) p_d.cnt = '0;
        else                          p_d.cnt = p_q.cnt + PRESC_W'(1);
        tick = run && (p_q.cnt == presc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R3: with a prescaler above zero two ticks are never adjacent
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc != '0) |=> !tick);

    // R3: the count never passes the programmed limit while running
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (p_q.cnt <= presc));

endmodule

// File: rtl/i2c_tmg_seq.sv
module i2c_tmg_seq
    import i2c_bus_timer_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int DLY_W   = 4,
    parameter int CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic               scl_in,
    input  logic               tick,
    input  logic [PHASE_W-1:0] low,
    input  logic [PHASE_W-1:0] high,
    input  logic [DLY_W-1:0]   hold,
    input  logic [DLY_W-1:0]   setup,
    output logic               run,
    output logic               cmd_ready,
    output logic               scl_fall_stb,
    output logic               sda_chg_stb,
    output logic               scl_rise_stb,
    output logic               done_stb
);
    typedef struct packed {
        tmg_state_e       st;
        logic [CNT_W-1:0] el;
        logic [CNT_W-1:0] tgt;
        logic             fall;
        logic             sda;
        logic             rise;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, el: '0, tgt: '0,
                                 fall: 1'b0, sda: 1'b0, rise: 1'b0, done: 1'b0};

    seq_t s_d, s_q;

    logic [CNT_W-1:0] low_len, high_len, data_len, rel_len, nxt_el;

    always_comb begin
        low_len  = CNT_W'(low) + CNT_W'(1);
        high_len = CNT_W'(high) + CNT_W'(1);
        data_len = CNT_W'(hold) + CNT_W'(setup) + CNT_W'(1);
        rel_len  = (low_len > data_len) ? low_len : data_len;
        nxt_el   = s_q.el + CNT_W'(1);
    end

    always_comb begin
        s_d      = s_q;
        s_d.fall = 1'b0;
        s_d.sda  = 1'b0;
        s_d.rise = 1'b0;
        s_d.done = 1'b0;
        if (!enable) begin
            s_d.st = ST_IDLE;
            s_d.el = '0;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (cmd_op)
                            OP_BIT: begin
                                s_d.st   = ST_LOW;
                                s_d.el   = '0;
                                s_d.fall = 1'b1;
                                s_d.sda  = (hold == '0);
                            end
                            OP_HIGH_IVAL: begin
                                s_d.st  = ST_IVAL;
                                s_d.el  = '0;
                                s_d.tgt = high_len;
                            end
                            OP_LOW_IVAL: begin
                                s_d.st  = ST_IVAL;
                                s_d.el  = '0;
                                s_d.tgt = low_len;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        s_d.el = nxt_el;
                        if (hold != '0 && nxt_el == CNT_W'(hold)) s_d.sda = 1'b1;
                        if (nxt_el == rel_len) begin
                            s_d.rise = 1'b1;
                            s_d.st   = ST_WAIT_HI;
                            s_d.el   = '0;
                        end
                    end
                end
                ST_WAIT_HI: begin
                    if (scl_in) begin
                        s_d.st = ST_HIGH;
                        s_d.el = '0;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        s_d.el = nxt_el;
                        if (nxt_el == high_len) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end
                    end
                end
                ST_IVAL: begin
                    if (tick) begin
                        s_d.el = nxt_el;
                        if (nxt_el == s_q.tgt) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign run          = (s_q.st == ST_LOW) || (s_q.st == ST_HIGH) || (s_q.st == ST_IVAL);
    assign cmd_ready    = enable && (s_q.st == ST_IDLE);
    assign scl_fall_stb = s_q.fall;
    assign sda_chg_stb  = s_q.sda;
    assign scl_rise_stb = s_q.rise;
    assign done_stb     = s_q.done;

    // R11: fall, rise and done strobes are mutually exclusive
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_fall_stb, scl_rise_stb, done_stb}));

    // R11: a fall strobe lasts a single cycle
    p_fall_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |=> !scl_fall_stb);

    // R6: a stretched (low) SCL keeps the high phase from starting
    p_stretch_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT_HI && !scl_in && enable) |=> (s_q.st == ST_WAIT_HI));

    // R10: a disabled edge silences every strobe in the next cycle
    p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(scl_fall_stb || sda_chg_stb || scl_rise_stb || done_stb));

    // R9: an accepted bit request produces the fall strobe next cycle
    p_accept_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_op == OP_BIT) |=> scl_fall_stb);

    // R9: nothing is started while not ready
    p_busy_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> !scl_fall_stb);

endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer #(
    parameter int PRESC_W = 4,
    parameter int PHASE_W = 8,
    parameter int DLY_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_we,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [PHASE_W-1:0] cfg_low,
    input  logic [PHASE_W-1:0] cfg_high,
    input  logic [DLY_W-1:0]   cfg_hold,
    input  logic [DLY_W-1:0]   cfg_setup,
    input  logic               scl_in,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    output logic               cmd_ready,
    output logic               scl_fall_stb,
    output logic               sda_chg_stb,
    output logic               scl_rise_stb,
    output logic               done_stb
);
    localparam int SPAN_W = (PHASE_W > DLY_W + 1) ? PHASE_W : DLY_W + 1;
    localparam int CNT_W  = SPAN_W + 1;

    logic [PRESC_W-1:0] presc_q;
    logic [PHASE_W-1:0] low_q, high_q;
    logic [DLY_W-1:0]   hold_q, setup_q;
    logic               run, tick;

    i2c_tmg_cfg #(
        .PRESC_W (PRESC_W),
        .PHASE_W (PHASE_W),
        .DLY_W   (DLY_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .wr       (cfg_we),
        .wr_presc (cfg_presc),
        .wr_low   (cfg_low),
        .wr_high  (cfg_high),
        .wr_hold  (cfg_hold),
        .wr_setup (cfg_setup),
        .presc    (presc_q),
        .low      (low_q),
        .high     (high_q),
        .hold     (hold_q),
        .setup    (setup_q)
    );

    i2c_tmg_presc #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .presc (presc_q),
        .tick  (tick)
    );

    i2c_tmg_seq #(
        .PHASE_W (PHASE_W),
        .DLY_W   (DLY_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .scl_in       (scl_in),
        .tick         (tick),
        .low          (low_q),
        .high         (high_q),
        .hold         (hold_q),
        .setup        (setup_q),
        .run          (run),
        .cmd_ready    (cmd_ready),
        .scl_fall_stb (scl_fall_stb),
        .sda_chg_stb  (sda_chg_stb),
        .scl_rise_stb (scl_rise_stb),
        .done_stb     (done_stb)
    );

endmodule

// File: tb/i2c_bus_timer_tb.sv
module i2c_bus_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_presc = '0;
    logic [7:0] cfg_low = '0;
    logic [7:0] cfg_high = '0;
    logic [3:0] cfg_hold = '0;
    logic [3:0] cfg_setup = '0;
    logic       scl_in = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic       cmd_ready, scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb;

    always #4 clk = ~clk;

    i2c_bus_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_presc(cfg_presc), .cfg_low(cfg_low), .cfg_high(cfg_high),
        .cfg_hold(cfg_hold), .cfg_setup(cfg_setup), .scl_in(scl_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .scl_fall_stb(scl_fall_stb), .sda_chg_stb(sda_chg_stb),
        .scl_rise_stb(scl_rise_stb), .done_stb(done_stb)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, act, exp, e);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int e = 0;
    int mmode = 0;            // 0 idle, 1 low, 2 wait high, 3 high, 4 interval
    int mp = 0, ml = 0, mh = 0, mhd = 0, msu = 0;
    int tsda = 0, trise = 0, tdone = 0;
    bit ef = 0, es = 0, er = 0, ed = 0;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    always @(posedge clk) begin
        int per;
        e++;
        ef = 0; es = 0; er = 0; ed = 0;
        per = mp + 1;
        if (!rst_n) begin
            mmode = 0;
            mp = 0; ml = 0; mh = 0; mhd = 0; msu = 0;
        end else begin
            if (!enable) mmode = 0;
            else begin
                case (mmode)
                    0: if (cmd_valid) begin
                        if (cmd_op == 2'd0) begin
                            mmode = 1; ef = 1;
                            if (mhd == 0) es = 1;
                            tsda  = e + mhd * per;
                            trise = e + imax(ml + 1, mhd + msu + 1) * per;
                        end else if (cmd_op == 2'd1) begin
                            mmode = 4; tdone = e + (mh + 1) * per;
                        end else if (cmd_op == 2'd2) begin
                            mmode = 4; tdone = e + (ml + 1) * per;
                        end
                    end
                    1: begin
                        if (mhd != 0 && e == tsda) es = 1;
                        if (e == trise) begin er = 1; mmode = 2; end
                    end
                    2: if (scl_in) begin mmode = 3; tdone = e + (mh + 1) * per; end
                    default: if (e == tdone) begin ed = 1; mmode = 0; end
                endcase
            end
            if (cfg_we && !enable) begin
                mp = cfg_presc; ml = cfg_low; mh = cfg_high; mhd = cfg_hold; msu = cfg_setup;
            end
        end
    end

    // ---------------- per-cycle comparison and SCL line emulation ----------------
    int  stretch = 0;
    int  rel_cnt = 0;
    bit  rel_pend = 0;

    always @(negedge clk) begin
        if (e >= 1) begin
            chk(scl_fall_stb == ef, "R3 fall strobe", scl_fall_stb, ef);
            chk(sda_chg_stb == es, "R4 sda strobe", sda_chg_stb, es);
            chk(scl_rise_stb == er, "R5 rise strobe", scl_rise_stb, er);
            chk(done_stb == ed, "R6/R7 done strobe", done_stb, ed);
            chk(cmd_ready == (enable && mmode == 0), "R9 ready", cmd_ready,
                int'(enable && mmode == 0));
            chk((int'(scl_fall_stb) + int'(scl_rise_stb) + int'(done_stb)) <= 1,
                "R11 exclusive strobes",
                int'(scl_fall_stb) + int'(scl_rise_stb) + int'(done_stb), 1);
        end
        if (scl_rise_stb) begin rel_pend = 1; rel_cnt = stretch; end
        if (rel_pend) begin
            if (rel_cnt == 0) begin scl_in = 1'b1; rel_pend = 0; end
            else rel_cnt--;
        end
        if (scl_fall_stb) begin scl_in = 1'b0; rel_pend = 0; end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (e > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", e, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus tasks (all entered just after a falling edge) ----------------
    task automatic write_cfg(input int p, input int l, input int h, input int hd, input int su);
        enable = 1'b0;
        cfg_we = 1'b1;
        cfg_presc = 4'(p); cfg_low = 8'(l); cfg_high = 8'(h);
        cfg_hold = 4'(hd); cfg_setup = 4'(su);
        @(negedge clk);
        cfg_we = 1'b0;
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic issue(input int op);
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        cmd_valid = 1'b1;
        cmd_op = 2'(op);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_stb) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_bit(input int s);
        stretch = s;
        issue(0);
        wait_done();
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_ready == 1'b0, "R1 ready in reset", cmd_ready, 0);
        chk({scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb} == 4'b0, "R1 strobes in reset",
            {scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R1 ready after reset, disabled", cmd_ready, 0);

        // R3/R4/R5/R6: unit prescaler, low dominates
        write_cfg(0, 3, 2, 1, 1);
        run_bit(0);
        // R4: zero hold, prescaler 3 clocks, stretched high
        write_cfg(2, 5, 1, 0, 1);
        run_bit(4);
        // R5: hold+setup exceeds low
        write_cfg(1, 1, 0, 4, 5);
        run_bit(1);
        // long phases
        write_cfg(3, 200, 100, 15, 15);
        run_bit(0);

        // R2: write while enabled is ignored
        write_cfg(1, 4, 1, 2, 1);
        cfg_we = 1'b1; cfg_presc = 4'd3; cfg_low = 8'd9; cfg_hold = 4'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        stretch = 0;
        issue(0);
        gap = 0;
        while (!scl_rise_stb) begin @(negedge clk); gap++; end
        chk(gap == 10, "R2 old timing kept (fall to rise clocks)", gap, 10);
        wait_done();

        // R7: interval operations
        write_cfg(2, 6, 3, 1, 1);
        issue(1);
        wait_done();
        issue(2);
        wait_done();

        // R8: reserved code ignored
        issue(3);
        #1;
        chk(cmd_ready == 1'b1, "R8 ready after reserved code", cmd_ready, 1);
        repeat (5) begin
            @(negedge clk); #1;
            chk({scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb} == 4'b0,
                "R8 no strobes after reserved code",
                {scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb}, 0);
        end

        // R9: back-to-back bits with request held
        stretch = 0;
        #1;
        cmd_valid = 1'b1; cmd_op = 2'd0;
        while (!done_stb) @(negedge clk);
        @(negedge clk);
        while (!done_stb) @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);

        // R10: abort mid low phase
        write_cfg(1, 20, 2, 3, 2);
        issue(0);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk); #1;
        chk(cmd_ready == 1'b0, "R10 ready while disabled", cmd_ready, 0);
        chk({scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb} == 4'b0,
            "R10 strobes after disable", {scl_fall_stb, sda_chg_stb, scl_rise_stb, done_stb}, 0);
        repeat (30) @(negedge clk);
        enable = 1'b1;
        #1;
        chk(cmd_ready == 1'b1, "R10 idle after re-enable", cmd_ready, 1);
        @(negedge clk);
        run_bit(2);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule